// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block is the memory management unit of an 8-bit computer with a 64 KB CPU address space. It holds two CPU-accessible I/O registers, a primary and a secondary paging register. From them it maps 16 KB RAM banks and ROM pages into the four 16 KB windows of the address space. It also chooses the screen bank the display fetches from, drives a CPU clock-speed select and drives two software-controlled open-drain I2C lines.

The CPU side is a Z80-style bus: a 16-bit address, write and read data, and active-low IORQ, RD and WR strobes. A register write takes effect at the clock edge on which the strobes are seen. For every address the block reports, in the same cycle, a physical page number, a flag saying whether that page is ROM or RAM, and a flag saying that the access touches a RAM bank shared with video. Two bits can lock the block down. A lock bit in the primary register freezes that register until reset. A downgrade bit in the secondary register hides every extended feature, which leaves a plain 128K-style machine.

Top module: `mem_page_ctrl`

## Requirements
- R1: After a synchronous reset both registers are 0. As a result, 0000h–3FFFh shows ROM page 0, 4000h–7FFFh shows RAM bank 5, C000h–FFFFh shows bank 0, the display page is 5 and the clock select is 0.
- R2: The 8000h–BFFFh window always maps RAM bank 2. The C000h–FFFFh window maps the RAM bank given by primary bits 2..0.
- R3: The display page is 5 when primary bit 3 is 0 and 7 when it is 1. The 4000h window is not affected by this bit.
- R4: When secondary bit 0 is 0, the 0000h window is ROM (mem_is_rom = 1) with page number {secondary bit 1, primary bit 4}.
- R5: When secondary bit 0 is 1, the 0000h window is RAM: bank 8 if secondary bit 1 is 0, bank 9 if it is 1.
- R6: Secondary bit 2 = 1 maps RAM bank 9 into 4000h–7FFFh and leaves the display page unchanged.
- R7: Once a value with bit 5 = 1 has been written to the primary register, every later primary write is ignored until reset. Reset clears the lock.
- R8: mem_contended is 1 exactly when the current address maps to RAM bank 2 or RAM bank 5.
- R9: turbo_clk follows secondary bit 3 (0 = normal rate, 1 = double rate).
- R10: While secondary bit 5 is 1, secondary writes are ignored, reads of either register leave cpu_rdata_en at 0, and both I2C lines are released. Primary writes still work.
- R11: The I2C lines are open-drain. scl_pull_low is 1 when secondary bit 6 is 0, and sda_pull_low is 1 when secondary bit 7 is 0. A secondary read returns the synchronised SCL level in bit 6, the SDA level in bit 7 and the stored bits 5..0.
- R12: A register responds only when the full 16-bit address matches: 7FFDh for the primary and 1FFDh for the secondary. Writes to any other I/O address change nothing.
- R13: A primary read returns all eight stored bits with cpu_rdata_en = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address (memory or I/O) |
| cpu_wdata | input | 8 | CPU write data |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cpu_rdata | output | 8 | Register read data |
| cpu_rdata_en | output | 1 | Read data valid, drive the bus |
| mem_page | output | 4 | Physical RAM bank or ROM page for cpu_addr |
| mem_is_rom | output | 1 | 1 when mem_page names a ROM page |
| mem_contended | output | 1 | Access hits a RAM bank shared with video |
| disp_page | output | 4 | RAM bank the display shows |
| turbo_clk | output | 1 | CPU clock-speed select |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull_low | output | 1 | Drive SCL low |
| sda_pull_low | output | 1 | Drive SDA low |

## Verification
The bench builds the block with its default decode addresses and with SYNC_STAGES = 2. That depth keeps the line read-back latency short, so an I2C level change made by the bench's own open-drain bus model shows up in a register read within a few cycles. The reference model holds both registers as plain integers and works out the mapping of each window on every cycle. Because of this, the sweeps over the four windows after each write reach every bank and ROM source, the lock, the downgrade and the near-miss I/O addresses.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int PG_W      = 4;
  localparam int WIN_SEL_W = 2;

  // primary register fields
  localparam int P_RAM_W   = 3;
  localparam int P_SHADOW  = 3;
  localparam int P_ROM_LO  = 4;
  localparam int P_LOCK    = 5;

  // secondary register fields
  localparam int S_RAM0    = 0;
  localparam int S_ROM_HI  = 1;
  localparam int S_ALT_MID = 2;
  localparam int S_TURBO   = 3;
  localparam int S_BASIC   = 5;
  localparam int S_SCL     = 6;
  localparam int S_SDA     = 7;

  localparam logic [PG_W-1:0] BK_SCR_NORM = 4'd5;
  localparam logic [PG_W-1:0] BK_SCR_ALT  = 4'd7;
  localparam logic [PG_W-1:0] BK_FIXED    = 4'd2;
  localparam logic [PG_W-1:0] BK_LOW_BASE = 4'd8;
  localparam logic [PG_W-1:0] BK_EXTRA    = 4'd9;

  typedef struct packed {
    logic            is_rom;
    logic [PG_W-1:0] page;
  } map_t;
endpackage

// File: rtl/mpc_sync.sv
module mpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2+((STAGES==1)?1:0):0] , d} >> ((STAGES==1)?0:0);
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mpc_io.sv
module mpc_io
  import mpc_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 16'h7FFD,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 16'h1FFD
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] pri_q,
  input  logic [S_SCL-1:0]  sec_lo,
  input  logic              lvl_scl,
  input  logic              lvl_sda,
  output logic              wr_pri,
  output logic              wr_sec,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);
  logic hit_pri, hit_sec, basic_mode, io_wr, io_rd;

  assign hit_pri    = (io_addr == PRI_ADDR);
  assign hit_sec    = (io_addr == SEC_ADDR);
  assign basic_mode = sec_lo[S_BASIC];
  assign io_wr      = !iorq_n && !wr_n;
  assign io_rd      = !iorq_n && !rd_n && !basic_mode;

  assign wr_pri = io_wr && hit_pri && !pri_q[P_LOCK];
  assign wr_sec = io_wr && hit_sec && !basic_mode;

  always_comb begin
    rdata    = '0;
    rdata_en = 1'b0;
    if (io_rd && hit_pri) begin
      rdata    = pri_q;
      rdata_en = 1'b1;
    end else if (io_rd && hit_sec) begin
      rdata[S_SCL-1:0] = sec_lo;
      rdata[S_SCL]     = lvl_scl;
      rdata[S_SDA]     = lvl_sda;
      rdata_en         = 1'b1;
    end
  end
endmodule

// File: rtl/mpc_xlate.sv
module mpc_xlate
  import mpc_pkg::*;
(
  input  logic [WIN_SEL_W-1:0] win_sel,
  input  logic [P_RAM_W-1:0]   top_bank,
  input  logic                 rom_lo,
  input  logic                 rom_hi,
  input  logic                 low_ram,
  input  logic                 alt_mid,
  output map_t                 map,
  output logic                 contended
);
  localparam int NWIN = 1 << WIN_SEL_W;

  map_t win_map [NWIN];

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      if (w == 0) begin : g_low
        always_comb begin
          if (low_ram) begin
            win_map[w].is_rom = 1'b0;
            win_map[w].page   = BK_LOW_BASE | {{(PG_W-1){1'b0}}, rom_hi};
          end else begin
            win_map[w].is_rom = 1'b1;
            win_map[w].page   = {{(PG_W-2){1'b0}}, rom_hi, rom_lo};
          end
        end
      end else if (w == 1) begin : g_scr
        always_comb begin
          win_map[w].is_rom = 1'b0;
          win_map[w].page   = alt_mid ? BK_EXTRA : BK_SCR_NORM;
        end
      end else if (w == 2) begin : g_fix
        always_comb begin
          win_map[w].is_rom = 1'b0;
          win_map[w].page   = BK_FIXED;
        end
      end else begin : g_top
        always_comb begin
          win_map[w].is_rom = 1'b0;
          win_map[w].page   = {{(PG_W-P_RAM_W){1'b0}}, top_bank};
        end
      end
    end
  endgenerate

  assign map       = win_map[win_sel];
  assign contended = !map.is_rom && ((map.page == BK_FIXED) || (map.page == BK_SCR_NORM));
endmodule

// File: rtl/mem_page_ctrl.sv
module mem_page_ctrl
  import mpc_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] PRI_ADDR    = 16'h7FFD,
  parameter logic [ADDR_W-1:0] SEC_ADDR    = 16'h1FFD,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_en,
  output logic [PG_W-1:0]   mem_page,
  output logic              mem_is_rom,
  output logic              mem_contended,
  output logic [PG_W-1:0]   disp_page,
  output logic              turbo_clk,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull_low,
  output logic              sda_pull_low
);
  logic [DATA_W-1:0] pri_q, sec_q;
  logic              wr_pri, wr_sec;
  logic              lvl_scl, lvl_sda;
  map_t              cur_map;

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      if (wr_pri) pri_q <= cpu_wdata;
      if (wr_sec) sec_q <= cpu_wdata;
    end
  end

  logic [1:0] line_raw, line_sync;
  assign line_raw = {sda_in, scl_in};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_line
      mpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_raw[i]),
        .q   (line_sync[i])
      );
    end
  endgenerate

  assign lvl_scl = line_sync[0];
  assign lvl_sda = line_sync[1];

  mpc_io #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PRI_ADDR (PRI_ADDR),
    .SEC_ADDR (SEC_ADDR)
  ) u_io (
    .io_addr  (cpu_addr),
    .iorq_n   (iorq_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .pri_q    (pri_q),
    .sec_lo   (sec_q[S_SCL-1:0]),
    .lvl_scl  (lvl_scl),
    .lvl_sda  (lvl_sda),
    .wr_pri   (wr_pri),
    .wr_sec   (wr_sec),
    .rdata    (cpu_rdata),
    .rdata_en (cpu_rdata_en)
  );

  mpc_xlate u_xlate (
    .win_sel   (cpu_addr[ADDR_W-1 -: WIN_SEL_W]),
    .top_bank  (pri_q[P_RAM_W-1:0]),
    .rom_lo    (pri_q[P_ROM_LO]),
    .rom_hi    (sec_q[S_ROM_HI]),
    .low_ram   (sec_q[S_RAM0]),
    .alt_mid   (sec_q[S_ALT_MID]),
    .map       (cur_map),
    .contended (mem_contended)
  );

  assign mem_page     = cur_map.page;
  assign mem_is_rom   = cur_map.is_rom;
  assign disp_page    = pri_q[P_SHADOW] ? BK_SCR_ALT : BK_SCR_NORM;
  assign turbo_clk    = sec_q[S_TURBO];
  assign scl_pull_low = !sec_q[S_BASIC] && !sec_q[S_SCL];
  assign sda_pull_low = !sec_q[S_BASIC] && !sec_q[S_SDA];
endmodule

// File: rtl/mpc_check.sv
module mpc_check
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [PG_W-1:0]   mem_page,
  input logic              mem_is_rom,
  input logic              mem_contended,
  input logic [PG_W-1:0]   disp_page,
  input logic [DATA_W-1:0] pri_q,
  input logic [DATA_W-1:0] sec_q,
  input logic              scl_pull_low,
  input logic              sda_pull_low
);
  logic [WIN_SEL_W-1:0] win;
  assign win = cpu_addr[ADDR_W-1 -: WIN_SEL_W];

  AST_MID_FIXED: assert property (@(posedge clk) disable iff (rst)
    (win == 2'd2) |-> (!mem_is_rom && mem_page == BK_FIXED)); // R2
  AST_TOP_IS_RAM: assert property (@(posedge clk) disable iff (rst)
    (win == 2'd3) |-> (!mem_is_rom && mem_page < 4'd8)); // R2
  AST_SCREEN_SET: assert property (@(posedge clk) disable iff (rst)
    (disp_page == BK_SCR_NORM) || (disp_page == BK_SCR_ALT)); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    pri_q[P_LOCK] |=> $stable(pri_q)); // R7
  AST_CONT_BANKS: assert property (@(posedge clk) disable iff (rst)
    mem_contended |-> (!mem_is_rom && (mem_page == BK_FIXED || mem_page == BK_SCR_NORM))); // R8
  AST_BASIC_FREEZE: assert property (@(posedge clk) disable iff (rst)
    sec_q[S_BASIC] |=> $stable(sec_q)); // R10
  AST_BASIC_RELEASE: assert property (@(posedge clk) disable iff (rst)
    sec_q[S_BASIC] |-> (!scl_pull_low && !sda_pull_low)); // R10
endmodule

bind mem_page_ctrl mpc_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mpc_check (
  .clk           (clk),
  .rst           (rst),
  .cpu_addr      (cpu_addr),
  .mem_page      (mem_page),
  .mem_is_rom    (mem_is_rom),
  .mem_contended (mem_contended),
  .disp_page     (disp_page),
  .pri_q         (pri_q),
  .sec_q         (sec_q),
  .scl_pull_low  (scl_pull_low),
  .sda_pull_low  (sda_pull_low)
);

// File: tb/test_mem_page_ctrl.sv
module test_mem_page_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_en;
  logic [3:0]  mem_page, disp_page;
  logic        mem_is_rom, mem_contended, turbo_clk;
  logic        scl_pull_low, sda_pull_low;
  logic        ext_scl = 1'b1, ext_sda = 1'b1;
  logic        scl_in, sda_in;

  assign scl_in = ext_scl & ~scl_pull_low;
  assign sda_in = ext_sda & ~sda_pull_low;

  always #5 clk = ~clk;

  mem_page_ctrl i_mem_page_ctrl (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .cpu_rdata(cpu_rdata), .cpu_rdata_en(cpu_rdata_en),
    .mem_page(mem_page), .mem_is_rom(mem_is_rom), .mem_contended(mem_contended),
    .disp_page(disp_page), .turbo_clk(turbo_clk),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  int m_pri = 0, m_sec = 0;
  bit m_valid = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference: register contents
  always @(posedge clk) begin
    if (rst) begin
      m_pri = 0; m_sec = 0; m_valid = 1;
    end else if (!iorq_n && !wr_n) begin
      if (cpu_addr == 16'h7FFD && ((m_pri >> 5) & 1) == 0) m_pri = cpu_wdata;
      else if (cpu_addr == 16'h1FFD && ((m_sec >> 5) & 1) == 0) m_sec = cpu_wdata;
    end
  end

  // per-cycle comparison of mapping outputs
  always @(negedge clk) begin
    if (m_valid && !rst) begin
      int win, rom, pg, cont, down;
      win = cpu_addr >> 14;
      down = (m_sec >> 5) & 1;
      case (win)
        0: if (m_sec & 1) begin rom = 0; pg = 8 + ((m_sec >> 1) & 1); end
           else begin rom = 1; pg = ((m_sec >> 1) & 1) * 2 + ((m_pri >> 4) & 1); end
        1: begin rom = 0; pg = (m_sec & 4) ? 9 : 5; end
        2: begin rom = 0; pg = 2; end
        default: begin rom = 0; pg = m_pri & 7; end
      endcase
      cont = (!rom && (pg == 2 || pg == 5)) ? 1 : 0;
      if (win == 0) begin
        chk((m_sec & 1) ? "R5 low RAM page" : "R4 ROM page", mem_page, pg);
        chk((m_sec & 1) ? "R5 low RAM flag" : "R4 ROM flag", mem_is_rom, rom);
      end else if (win == 1) begin
        chk("R6 4000h page", mem_page, pg);
        chk("R6 4000h flag", mem_is_rom, rom);
      end else begin
        chk("R2 upper page", mem_page, pg);
        chk("R2 upper flag", mem_is_rom, rom);
      end
      chk("R8 contention", mem_contended, cont);
      chk("R3 display page", disp_page, ((m_pri >> 3) & 1) ? 7 : 5);
      chk("R9 clock select", turbo_clk, (m_sec >> 3) & 1);
      chk(down ? "R10 SCL release" : "R11 SCL drive", scl_pull_low, (!down && !((m_sec >> 6) & 1)) ? 1 : 0);
      chk(down ? "R10 SDA release" : "R11 SDA drive", sda_pull_low, (!down && !((m_sec >> 7) & 1)) ? 1 : 0);
    end
  end

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; iorq_n = 0; wr_n = 0;
    @(posedge clk); #1;
    iorq_n = 1; wr_n = 1;
  endtask

  task automatic io_rd(input logic [15:0] a, input int exp_en, input int exp_d, input string tag);
    @(posedge clk); #1;
    cpu_addr = a; iorq_n = 0; rd_n = 0;
    @(negedge clk);
    chk({tag, " read enable"}, cpu_rdata_en, exp_en);
    if (exp_en) chk({tag, " read data"}, cpu_rdata, exp_d);
    @(posedge clk); #1;
    iorq_n = 1; rd_n = 1;
  endtask

  task automatic sweep();
    for (int w = 0; w < 4; w++) begin
      @(posedge clk); #1;
      cpu_addr = 16'(w * 16'h4000 + 16'h0123);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 reset clock select", turbo_clk, 0);
    chk("R1 reset display", disp_page, 5);
    sweep();
    repeat (3) @(posedge clk);
    io_rd(16'h7FFD, 1, 8'h00, "R1 primary");
    io_rd(16'h1FFD, 1, 8'h00, "R1 secondary");

    io_wr(16'h7FFD, 8'h03); sweep();
    io_wr(16'h7FFD, 8'h0D); sweep();
    io_wr(16'h7FFD, 8'h17); sweep();
    io_rd(16'h7FFD, 1, 8'h17, "R13 primary");
    io_wr(16'h7FFD, 8'hC2); sweep();
    io_rd(16'h7FFD, 1, 8'hC2, "R13 primary upper bits");

    io_wr(16'h1FFD, 8'h02); sweep();
    io_wr(16'h7FFD, 8'h10); sweep();
    io_wr(16'h1FFD, 8'h01); sweep();
    io_wr(16'h1FFD, 8'h03); sweep();
    io_wr(16'h1FFD, 8'h04); sweep();
    io_wr(16'h7FFD, 8'h08); sweep();
    io_wr(16'h1FFD, 8'h08); sweep();

    // I2C lines released, external device drives them
    io_wr(16'h1FFD, 8'hC0); sweep();
    io_rd(16'h1FFD, 1, 8'hC0, "R11 lines high");
    ext_scl = 0; sweep();
    io_rd(16'h1FFD, 1, 8'h80, "R11 SCL low");
    ext_scl = 1; ext_sda = 0; sweep();
    io_rd(16'h1FFD, 1, 8'h40, "R11 SDA low");
    ext_sda = 1;
    io_wr(16'h1FFD, 8'h40); sweep();
    io_rd(16'h1FFD, 1, 8'h40, "R11 SDA pulled");

    // near-miss addresses
    io_wr(16'h7FFC, 8'h07);
    io_wr(16'hFFFD, 8'h06);
    io_wr(16'h1FFC, 8'h0F);
    io_wr(16'h3FFD, 8'h0F);
    sweep();
    io_rd(16'h7FFD, 1, 8'h08, "R12 primary unchanged");
    io_rd(16'h1FFD, 1, 8'h40, "R12 secondary unchanged");

    // lock
    io_wr(16'h7FFD, 8'h21); sweep();
    io_wr(16'h7FFD, 8'h06); sweep();
    io_rd(16'h7FFD, 1, 8'h21, "R7 locked primary");
    io_wr(16'h1FFD, 8'hC1); sweep();
    io_rd(16'h1FFD, 1, 8'hC1, "R7 secondary still open");
    do_reset(); sweep();
    io_rd(16'h7FFD, 1, 8'h00, "R7 reset unlocks");
    io_wr(16'h7FFD, 8'h06); sweep();
    io_rd(16'h7FFD, 1, 8'h06, "R7 write after reset");

    // downgrade
    io_wr(16'h1FFD, 8'h2C); sweep();
    io_wr(16'h1FFD, 8'h00); sweep();
    io_rd(16'h1FFD, 0, 0, "R10 secondary hidden");
    io_rd(16'h7FFD, 0, 0, "R10 primary hidden");
    io_wr(16'h7FFD, 8'h0B); sweep();
    @(negedge clk);
    chk("R10 clock select kept", turbo_clk, 1);
    chk("R10 SCL released", scl_pull_low, 0);
    do_reset(); sweep();
    io_rd(16'h1FFD, 1, 8'h00, "R1 secondary after reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule